// File: doc/BRIEF.md
# Three-Wire Codec Control Slave

This block is the receive side of a three-wire serial control bus used to program an audio codec. The bus carries a mode line, a bit clock and a data line, all driven by an external controller and asynchronous to the chip. The block samples the three lines with its own system clock. It assembles 8-bit bytes on falling edges of the bus clock, most significant bit first. It uses the level of the mode line to tell address bytes from data-mode bytes, and decodes the data-mode bytes into a set of codec control fields.

A low mode level marks an address phase. When the upper six bits of an address byte match the device address, the two low bits pick how the data-mode bytes that follow are routed. They go either to the status register or to a group of data registers, and within that group a variable-length prefix in each byte selects the target. The routing stays in force until the next address phase, including across short low pulses on the mode line that separate data bytes. Every register write raises a one-cycle update strobe. What the fields mean for the audio path is decided by the consumers of the outputs.

The shifter runs the states SH_IDLE (no bits held) and SH_RECV (byte in progress). SH_IDLE goes to SH_RECV on a bus clock fall with the mode level steady. SH_RECV goes back to SH_IDLE when the eighth bit arrives, and also when the mode line changes level, which discards the partial byte. The decoder runs the routing states RT_NONE (data-mode bytes ignored), RT_DATA and RT_STATUS. Each completed address byte moves it to RT_DATA (match, type 00), RT_STATUS (match, type 10) or RT_NONE (any other address byte).

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset the outputs are vol=6'b000001 (0 dB), mute=0, adc_en=1, dac_en=1, and sys_rate, in_fmt, dc_filt, bass, treb, deemph and fmode are all zero; upd is 0.
- R2: Bits are taken from bus_data on falling edges of bus_clk, first bit as bit 7. A byte completed with bus_mode low is an address byte. If its bits 7:2 equal 6'b000101, bits 1:0 = 2'b00 select data routing and 2'b10 select status routing.
- R3: Under status routing, a byte with bits 7:6 = 2'b00 loads sys_rate from bits 5:4, in_fmt from bits 3:1 and dc_filt from bit 0. A status byte with bits 7:6 not 00 changes nothing.
- R4: Under data routing, a byte whose bits 7:6 are 2'b00 loads vol from bits 5:0.
- R5: Under data routing, a byte whose bits 7:6 are 2'b01 loads bass from bits 5:2 and treb from bits 1:0.
- R6: Under data routing, a byte whose bits 7:5 are 3'b100 loads deemph from bits 4:3, mute from bit 2 and fmode from bits 1:0.
- R7: Under data routing, a byte whose bits 7:2 are 6'b110000 loads adc_en from bit 1 and dac_en from bit 0. Data bytes with any other prefix (101, 111, or 11 followed by a non-zero 0000 field) change nothing.
- R8: The selected routing applies to every following data-mode byte, including bytes separated by a low pulse on bus_mode that carries no clock falls, until another address byte completes.
- R9: After an address byte whose bits 7:2 differ from 6'b000101, or whose bits 1:0 are 01 or 11, all data-mode bytes are ignored.
- R10: A byte in progress is discarded when bus_mode changes level before its eighth bit. The next byte starts from an empty shifter, and a discarded address byte leaves the routing unchanged.
- R11: upd is high for exactly one system clock cycle for each byte that writes a register, and stays low for ignored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 1 | Mode line: low for address, high for data; idles high |
| bus_clk | input | 1 | Bus bit clock; idles high, data taken on its falling edge |
| bus_data | input | 1 | Bus data line |
| sys_rate | output | 2 | System clock rate code (00 512fs, 01 384fs, 10 256fs) |
| in_fmt | output | 3 | Input data format code (000 I2S) |
| dc_filt | output | 1 | DC filter enable |
| vol | output | 6 | Volume code, 000001 = 0 dB, 1 dB lower per step |
| bass | output | 4 | Bass boost code |
| treb | output | 2 | Treble code |
| deemph | output | 2 | De-emphasis select (00 none, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) |
| mute | output | 1 | Mute enable |
| fmode | output | 2 | Tone filter mode (00 flat, 01/10 minimum, 11 maximum) |
| adc_en | output | 1 | ADC power enable |
| dac_en | output | 1 | DAC power enable |
| upd | output | 1 | One-cycle strobe on every register write |

## Verification
The hardest case to reach from the ports is a mode-line level change that lands in the middle of a byte. A well-behaved controller never does this, and a design that keeps the stale bits only shows the fault when the misaligned byte happens to decode to a write. The bench sends a run of ones that stops after five bits of a data byte, then pulses the mode line and sends a full volume byte. If the partial bits were kept, that byte would be misaligned into an ignored prefix and the volume would not change. It also cuts an address byte short mid-way and checks that the earlier data routing still steers the next byte.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 6;
    localparam int VOL_W    = 6;
    localparam int BASS_W   = 4;

    localparam logic [1:0] TYPE_DATA   = 2'b00;
    localparam logic [1:0] TYPE_STATUS = 2'b10;

    typedef enum logic [1:0] {
        RT_NONE   = 2'd0,
        RT_DATA   = 2'd1,
        RT_STATUS = 2'd2
    } route_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RECV = 1'b1
    } shift_t;

    typedef struct packed {
        logic [1:0]        sys_rate;
        logic [2:0]        in_fmt;
        logic              dc_filt;
        logic [VOL_W-1:0]  vol;
        logic [BASS_W-1:0] bass;
        logic [1:0]        treb;
        logic [1:0]        deemph;
        logic              mute;
        logic [1:0]        fmode;
        logic              adc_en;
        logic              dac_en;
    } ctl_regs_t;

    localparam ctl_regs_t REGS_RST = '{
        sys_rate: 2'b00,
        in_fmt:   3'b000,
        dc_filt:  1'b0,
        vol:      6'b000001,
        bass:     4'b0000,
        treb:     2'b00,
        deemph:   2'b00,
        mute:     1'b0,
        fmode:    2'b00,
        adc_en:   1'b1,
        dac_en:   1'b1
    };

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int         STAGES  = 2,
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_s,
    input  logic         sck_s,
    input  logic         sda_s,
    output logic         byte_vld,
    output logic         byte_addr,
    output logic [W-1:0] byte_q
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    shift_t        state, nxt;
    logic          sck_d, mode_d;
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;
    logic          fall, mchg;

    assign fall = sck_d & ~sck_s;
    assign mchg = mode_d ^ mode_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b1;
            mode_d <= 1'b1;
        end else begin
            sck_d  <= sck_s;
            mode_d <= mode_s;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE: if (!mchg && fall) nxt = SH_RECV;
            SH_RECV: begin
                if (mchg)                      nxt = SH_IDLE;
                else if (fall && cnt == LAST)  nxt = SH_IDLE;
            end
            default: nxt = SH_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh        <= '0;
            byte_vld  <= 1'b0;
            byte_addr <= 1'b0;
            byte_q    <= '0;
        end else begin
            byte_vld <= 1'b0;
            unique case (state)
                SH_IDLE: begin
                    cnt <= '0;
                    if (!mchg && fall) begin
                        sh  <= {sh[W-2:0], sda_s};
                        cnt <= CW'(1);
                    end
                end
                SH_RECV: begin
                    if (mchg) begin
                        cnt <= '0;
                    end else if (fall) begin
                        sh <= {sh[W-2:0], sda_s};
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            byte_vld  <= 1'b1;
                            byte_addr <= ~mode_s;
                            byte_q    <= {sh[W-2:0], sda_s};
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R10: a level change on the mode line empties the shifter
    p_mode_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mchg |=> (state == SH_IDLE && !byte_vld));

    // R2: a completed byte is always caused by a bus clock fall
    p_byte_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(fall));

endmodule

// File: rtl/tw_decoder.sv
module tw_decoder
    import tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_addr,
    input  logic [BYTE_W-1:0] byte_q,
    output ctl_regs_t         regs,
    output logic              upd
);

    route_t route, route_nxt;
    logic   hit;

    assign hit = (byte_q[BYTE_W-1 -: ADDR_W] == DEV_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) route <= RT_NONE;
        else        route <= route_nxt;
    end

    // transitions: only a completed address byte moves the routing
    always_comb begin
        route_nxt = route;
        if (byte_vld && byte_addr) begin
            if (hit && byte_q[1:0] == TYPE_DATA)        route_nxt = RT_DATA;
            else if (hit && byte_q[1:0] == TYPE_STATUS) route_nxt = RT_STATUS;
            else                                        route_nxt = RT_NONE;
        end
    end

    // register writes and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= REGS_RST;
            upd  <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (byte_vld && !byte_addr) begin
                unique case (route)
                    RT_STATUS: begin
                        if (byte_q[7:6] == 2'b00) begin
                            regs.sys_rate <= byte_q[5:4];
                            regs.in_fmt   <= byte_q[3:1];
                            regs.dc_filt  <= byte_q[0];
                            upd           <= 1'b1;
                        end
                    end
                    RT_DATA: begin
                        casez (byte_q)
                            8'b00??????: begin
                                regs.vol <= byte_q[5:0];
                                upd      <= 1'b1;
                            end
                            8'b01??????: begin
                                regs.bass <= byte_q[5:2];
                                regs.treb <= byte_q[1:0];
                                upd       <= 1'b1;
                            end
                            8'b100?????: begin
                                regs.deemph <= byte_q[4:3];
                                regs.mute   <= byte_q[2];
                                regs.fmode  <= byte_q[1:0];
                                upd         <= 1'b1;
                            end
                            8'b110000??: begin
                                regs.adc_en <= byte_q[1];
                                regs.dac_en <= byte_q[0];
                                upd         <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    RT_NONE: ;
                    default: ;
                endcase
            end
        end
    end

    // R11: strobe lasts one cycle
    p_upd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    // R11: strobe only follows a completed byte
    p_upd_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(byte_vld && !byte_addr));

    // R11: registers move only together with the strobe
    p_regs_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(regs));

    // R9: no routing means no write
    p_unrouted_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_NONE && byte_vld && !byte_addr) |=> !upd);

    // R2: matching data-type address selects data routing
    p_select_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_addr && hit && byte_q[1:0] == TYPE_DATA) |=> route == RT_DATA);

    // R8: data-mode bytes never change the routing
    p_route_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && byte_addr) |=> $stable(route));

endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
    import tw_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 6'b000101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_mode,
    input  logic       bus_clk,
    input  logic       bus_data,
    output logic [1:0] sys_rate,
    output logic [2:0] in_fmt,
    output logic       dc_filt,
    output logic [5:0] vol,
    output logic [3:0] bass,
    output logic [1:0] treb,
    output logic [1:0] deemph,
    output logic       mute,
    output logic [1:0] fmode,
    output logic       adc_en,
    output logic       dac_en,
    output logic       upd
);

    logic [2:0]        lines_s;
    logic              byte_vld, byte_addr;
    logic [BYTE_W-1:0] byte_q;
    ctl_regs_t         regs;

    tw_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b111)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({bus_mode, bus_clk, bus_data}),
        .sync_out(lines_s)
    );

    tw_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_s   (lines_s[2]),
        .sck_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .byte_vld (byte_vld),
        .byte_addr(byte_addr),
        .byte_q   (byte_q)
    );

    tw_decoder #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_addr(byte_addr),
        .byte_q   (byte_q),
        .regs     (regs),
        .upd      (upd)
    );

    assign sys_rate = regs.sys_rate;
    assign in_fmt   = regs.in_fmt;
    assign dc_filt  = regs.dc_filt;
    assign vol      = regs.vol;
    assign bass     = regs.bass;
    assign treb     = regs.treb;
    assign deemph   = regs.deemph;
    assign mute     = regs.mute;
    assign fmode    = regs.fmode;
    assign adc_en   = regs.adc_en;
    assign dac_en   = regs.dac_en;

endmodule

// File: tb/sim_tw_ctrl_slave.sv
`timescale 1ns/1ps
module sim_tw_ctrl_slave;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 1'b1, bus_clk = 1'b1, bus_data = 1'b0;
    logic [1:0] sys_rate, treb, deemph, fmode;
    logic [2:0] in_fmt;
    logic [5:0] vol;
    logic [3:0] bass;
    logic dc_filt, mute, adc_en, dac_en, upd;

    int checks = 0, failures = 0, upd_cnt = 0;

    always #10 clk = ~clk;

    tw_ctrl_slave u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_mode(bus_mode), .bus_clk(bus_clk), .bus_data(bus_data),
        .sys_rate(sys_rate), .in_fmt(in_fmt), .dc_filt(dc_filt),
        .vol(vol), .bass(bass), .treb(treb), .deemph(deemph),
        .mute(mute), .fmode(fmode), .adc_en(adc_en), .dac_en(dac_en),
        .upd(upd)
    );

    always @(posedge clk) if (rst_n && upd) upd_cnt <= upd_cnt + 1;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            bus_data = b[7-i];
            wait_n(HALF);
            bus_clk = 1'b0;
            wait_n(HALF);
            bus_clk = 1'b1;
            wait_n(HALF);
        end
    endtask

    task automatic addr_byte(input logic [7:0] b);
        bus_mode = 1'b0;
        wait_n(HALF);
        put_bits(b, 8);
        bus_mode = 1'b1;
        wait_n(HALF);
    endtask

    task automatic data_byte(input logic [7:0] b);
        put_bits(b, 8);
        wait_n(8);
    endtask

    task automatic mode_pulse();
        bus_mode = 1'b0;
        wait_n(HALF);
        bus_mode = 1'b1;
        wait_n(HALF);
    endtask

    task automatic t_reset();
        check("R1 vol", vol, 1);
        check("R1 mute", mute, 0);
        check("R1 adc_en", adc_en, 1);
        check("R1 dac_en", dac_en, 1);
        check("R1 others", {sys_rate, in_fmt, dc_filt, bass, treb, deemph, fmode}, 0);
        check("R1 upd", upd, 0);
    endtask

    task automatic t_status();
        int u0c;
        u0c = upd_cnt;
        addr_byte(8'h16);
        data_byte(8'h11);
        check("R3 sys_rate", sys_rate, 1);
        check("R3 in_fmt", in_fmt, 0);
        check("R3 dc_filt", dc_filt, 1);
        data_byte(8'h2E);
        check("R8 status repeat rate", sys_rate, 2);
        check("R8 status repeat fmt", in_fmt, 7);
        check("R8 status repeat dc", dc_filt, 0);
        data_byte(8'h80);
        check("R3 bad status ignored", {sys_rate, in_fmt, dc_filt}, {2'd2, 3'd7, 1'b0});
        check("R3 status leaves vol", vol, 1);
        check("R11 status strobes", upd_cnt - u0c, 2);
    endtask

    task automatic t_data();
        int u0c;
        u0c = upd_cnt;
        addr_byte(8'h14);
        data_byte(8'h05);
        check("R4 vol", vol, 5);
        data_byte(8'h6E);
        check("R5 bass", bass, 11);
        check("R5 treb", treb, 2);
        data_byte(8'h97);
        check("R6 deemph", deemph, 2);
        check("R6 mute", mute, 1);
        check("R6 fmode", fmode, 3);
        data_byte(8'hC1);
        check("R7 adc_en", adc_en, 0);
        check("R7 dac_en", dac_en, 1);
        check("R2 data route keeps status", sys_rate, 2);
        check("R11 data strobes", upd_cnt - u0c, 4);
    endtask

    task automatic t_persist();
        int u0c;
        u0c = upd_cnt;
        mode_pulse();
        data_byte(8'h3C);
        check("R8 after mode pulse", vol, 60);
        mode_pulse();
        data_byte(8'hA5);
        data_byte(8'hC5);
        check("R7 bad prefix ignored", {adc_en, dac_en, mute, deemph}, {1'b0, 1'b1, 1'b1, 2'd2});
        check("R11 ignored no strobe", upd_cnt - u0c, 1);
    endtask

    task automatic t_nomatch();
        int u0c;
        u0c = upd_cnt;
        addr_byte(8'h24);
        data_byte(8'h0A);
        check("R9 wrong address", vol, 60);
        addr_byte(8'h15);
        data_byte(8'h0B);
        check("R9 type 01", vol, 60);
        addr_byte(8'h17);
        data_byte(8'h0C);
        data_byte(8'h2C);
        check("R9 type 11", vol, 60);
        check("R9 type 11 status", sys_rate, 2);
        check("R11 no strobes when unrouted", upd_cnt - u0c, 0);
    endtask

    task automatic t_partial();
        addr_byte(8'h14);
        put_bits(8'hFF, 5);
        mode_pulse();
        data_byte(8'h02);
        check("R10 partial data dropped", vol, 2);
        bus_mode = 1'b0;
        wait_n(HALF);
        put_bits(8'h16, 4);
        bus_mode = 1'b1;
        wait_n(HALF);
        data_byte(8'h07);
        check("R10 partial address dropped", vol, 7);
        check("R2 msb first", bass, 11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_status();
        t_data();
        t_persist();
        t_nomatch();
        t_partial();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule